// File: doc/BRIEF.md
# Capture Attacker Selector

Once a capture target square has been chosen, this block works out which pieces of the side to move can capture on that square. It then hands back the cheapest attacker that has not been tried yet. The board arrives as a flat array of 64 four-bit square codes. It comes with the colour to move, the target index and a 64-bit mask of attackers already tried.

The target square acts as if it held a piece with every movement pattern at once. Its sliding component travels outward along the eight rays and stops at the first occupied square. Its knight, king and pawn components are judged from the geometry between each square and the target. A square with a piece of the moving side becomes a candidate only when the kind of signal reaching it matches how that piece moves. A comparator tree over the 64 candidates picks the winner, and the result is registered one clock cycle after the start strobe.

Top module: `atk_src_finder`

## Requirements
- R1: After synchronous reset, `found_o`, `done_o` and `from_o` are all zero.
- R2: `done_o` is high for exactly the one cycle that follows a cycle with `start_i` high, and is low otherwise.
- R3: Square s = rank*8 + file occupies `board_i[4s+3:4s]`. Bit 3 is the colour (0 white, 1 black) and bits 2:0 are the kind: 0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king. A rook or queen attacks along a rank or file only when every square strictly between it and the target is empty.
- R4: A bishop or queen attacks along a diagonal only when every square strictly between it and the target is empty.
- R5: A knight attacks when its file and rank distances to the target are (1,2) or (2,1). Index offsets that wrap across the board edge do not count.
- R6: A king attacks when it is one step away from the target in any of the eight directions.
- R7: A white pawn attacks from one rank below the target and one file to either side. A black pawn attacks from one rank above the target and one file to either side. A pawn on the opposite side of the target is not an attacker.
- R8: Only pieces whose colour equals `stm_i` are candidates. Pieces of the other colour are never selected.
- R9: The selected candidate has the lowest value, with pawn 1, knight 3, bishop 3, rook 5, queen 9 and king 12. Among equal values the lower square index wins.
- R10: Squares whose bit is set in `tried_i` are excluded. When no candidate remains, `found_o` is 0 and `from_o` is 0.
- R11: `from_o` and `found_o` change only on the clock edge that samples `start_i` high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_i | input | 256 | 64 square codes, 4 bits each |
| stm_i | input | 1 | Colour to move (0 white, 1 black) |
| target_i | input | 6 | Target square index |
| tried_i | input | 64 | Attackers already tried |
| start_i | input | 1 | Request strobe |
| from_o | output | 6 | Selected from-square |
| found_o | output | 1 | A candidate was selected |
| done_o | output | 1 | Result valid pulse |

## Verification
The hardest cases to reach are near-misses. In these a piece lies at a linear index offset that would be a legal jump or step, but that offset wraps around a board edge. Another near-miss is a slider whose ray is cut by a single intervening piece. Random boards rarely produce either, so directed positions place targets on the a- and h-files with knights, pawns and rooks at the wrapping offsets. They also put a lone blocker in an otherwise open line. Priority and exclusion are exercised by layering several attackers on one target and growing the tried mask until nothing is left.

// File: rtl/atk_pkg.sv
package atk_pkg;
    localparam int FILES  = 8;
    localparam int RANKS  = 8;
    localparam int NSQ    = FILES * RANKS;
    localparam int SQW    = $clog2(NSQ);
    localparam int CODEW  = 4;
    localparam int PRIW   = 4;
    localparam int BOARDW = NSQ * CODEW;
    localparam int NDIR   = 8;

    typedef enum logic [2:0] {
        PC_NONE   = 3'd0,
        PC_PAWN   = 3'd1,
        PC_KNIGHT = 3'd2,
        PC_BISHOP = 3'd3,
        PC_ROOK   = 3'd4,
        PC_QUEEN  = 3'd5,
        PC_KING   = 3'd6
    } piece_e;

    typedef struct packed {
        logic   black;
        piece_e kind;
    } sq_code_t;

    typedef struct packed {
        logic            valid;
        logic [PRIW-1:0] prio;
        logic [SQW-1:0]  idx;
    } cand_t;

    function automatic logic [PRIW-1:0] piece_value(piece_e k);
        case (k)
            PC_PAWN:   return PRIW'(1);
            PC_KNIGHT: return PRIW'(3);
            PC_BISHOP: return PRIW'(3);
            PC_ROOK:   return PRIW'(5);
            PC_QUEEN:  return PRIW'(9);
            PC_KING:   return PRIW'(12);
            default:   return PRIW'(15);
        endcase
    endfunction

    // higher priority wins, lower index breaks ties
    function automatic cand_t pick_better(cand_t a, cand_t b);
        if (!b.valid) return a;
        if (!a.valid) return b;
        if (b.prio > a.prio) return b;
        if ((b.prio == a.prio) && (b.idx < a.idx)) return b;
        return a;
    endfunction
endpackage

// File: rtl/atk_ray_walk.sv
module atk_ray_walk
    import atk_pkg::*;
(
    input  logic [NSQ-1:0] occ_i,
    input  logic [SQW-1:0] tgt_i,
    output logic [NSQ-1:0] ortho_o,
    output logic [NSQ-1:0] diag_o
);
    function automatic int step_f(int d);
        case (d)
            0, 4, 5: return 1;
            1, 6, 7: return -1;
            default: return 0;
        endcase
    endfunction

    function automatic int step_r(int d);
        case (d)
            2, 4, 6: return 1;
            3, 5, 7: return -1;
            default: return 0;
        endcase
    endfunction

    int             f, r;
    logic           open;
    logic [SQW-1:0] p;

    always_comb begin
        ortho_o = '0;
        diag_o  = '0;
        f = 0;
        r = 0;
        open = 1'b0;
        p = '0;
        for (int d = 0; d < NDIR; d++) begin
            f = int'(tgt_i) % FILES;
            r = int'(tgt_i) / FILES;
            open = 1'b1;
            for (int k = 1; k < FILES; k++) begin
                f = f + step_f(d);
                r = r + step_r(d);
                if (open && f >= 0 && f < FILES && r >= 0 && r < RANKS) begin
                    p = SQW'(r * FILES + f);
                    if (d < 4) ortho_o[p] = 1'b1;
                    else       diag_o[p]  = 1'b1;
                    if (occ_i[p]) open = 1'b0;
                end else begin
                    open = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/atk_sq_cell.sv
module atk_sq_cell
    import atk_pkg::*;
#(
    parameter int SQ = 0
) (
    input  logic [CODEW-1:0] code_i,
    input  logic             stm_i,
    input  logic [SQW-1:0]   tgt_i,
    input  logic             tried_i,
    input  logic             ortho_i,
    input  logic             diag_i,
    output cand_t            cand_o
);
    localparam int SF = SQ % FILES;
    localparam int SR = SQ / FILES;

    sq_code_t pc;
    int       df, dr, adf, adr;
    logic     leap, step, pawn_ok, accept;

    always_comb begin
        pc  = sq_code_t'(code_i);
        df  = SF - int'(tgt_i) % FILES;
        dr  = SR - int'(tgt_i) / FILES;
        adf = (df < 0) ? -df : df;
        adr = (dr < 0) ? -dr : dr;
        leap    = ((adf == 1) && (adr == 2)) || ((adf == 2) && (adr == 1));
        step    = (adf <= 1) && (adr <= 1) && ((adf + adr) != 0);
        pawn_ok = (adf == 1) && (pc.black ? (dr == 1) : (dr == -1));
        case (pc.kind)
            PC_PAWN:   accept = pawn_ok;
            PC_KNIGHT: accept = leap;
            PC_BISHOP: accept = diag_i;
            PC_ROOK:   accept = ortho_i;
            PC_QUEEN:  accept = ortho_i | diag_i;
            PC_KING:   accept = step;
            default:   accept = 1'b0;
        endcase
        cand_o.valid = accept && (pc.black == stm_i) && !tried_i;
        cand_o.prio  = PRIW'(15) - piece_value(pc.kind);
        cand_o.idx   = SQW'(SQ);
    end
endmodule

// File: rtl/atk_pick_tree.sv
module atk_pick_tree
    import atk_pkg::*;
(
    input  cand_t leaf_i [NSQ],
    output cand_t best_o
);
    localparam int LG = $clog2(NSQ);

    for (genvar lv = 0; lv <= LG; lv++) begin : g_lv
        localparam int W = NSQ >> lv;
        cand_t v [W];
        if (lv == 0) begin : g_leaf
            for (genvar j = 0; j < W; j++) begin : g_j
                assign v[j] = leaf_i[j];
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_j
                assign v[j] = pick_better(g_lv[lv-1].v[2*j], g_lv[lv-1].v[2*j+1]);
            end
        end
    end

    assign best_o = g_lv[LG].v[0];
endmodule

// File: rtl/atk_src_finder.sv
module atk_src_finder
    import atk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BOARDW-1:0] board_i,
    input  logic              stm_i,
    input  logic [SQW-1:0]    target_i,
    input  logic [NSQ-1:0]    tried_i,
    input  logic              start_i,
    output logic [SQW-1:0]    from_o,
    output logic              found_o,
    output logic              done_o
);
    logic [NSQ-1:0] occ, ortho, diag;
    cand_t          leaf [NSQ];
    cand_t          best;

    for (genvar s = 0; s < NSQ; s++) begin : g_sq
        sq_code_t sc;
        assign sc     = sq_code_t'(board_i[s*CODEW +: CODEW]);
        assign occ[s] = (sc.kind != PC_NONE);

        atk_sq_cell #(.SQ(s)) u_cell (
            .code_i  (board_i[s*CODEW +: CODEW]),
            .stm_i   (stm_i),
            .tgt_i   (target_i),
            .tried_i (tried_i[s]),
            .ortho_i (ortho[s]),
            .diag_i  (diag[s]),
            .cand_o  (leaf[s])
        );
    end

    atk_ray_walk u_rays (
        .occ_i   (occ),
        .tgt_i   (target_i),
        .ortho_o (ortho),
        .diag_o  (diag)
    );

    atk_pick_tree u_tree (
        .leaf_i (leaf),
        .best_o (best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            from_o  <= '0;
            found_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                found_o <= best.valid;
                from_o  <= best.valid ? best.idx : '0;
            end
        end
    end
endmodule

// File: rtl/atk_src_finder_chk.sv
module atk_src_finder_chk
    import atk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BOARDW-1:0] board_i,
    input logic              stm_i,
    input logic [NSQ-1:0]    tried_i,
    input logic              start_i,
    input logic [SQW-1:0]    from_o,
    input logic              found_o,
    input logic              done_o
);
    logic [BOARDW-1:0] cap_board;
    logic              cap_stm;
    logic [NSQ-1:0]    cap_tried;
    sq_code_t          sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_board <= '0;
            cap_stm   <= 1'b0;
            cap_tried <= '0;
        end else if (start_i) begin
            cap_board <= board_i;
            cap_stm   <= stm_i;
            cap_tried <= tried_i;
        end
    end

    assign sel = sq_code_t'(cap_board[int'(from_o)*CODEW +: CODEW]);

    p_done_follows_start_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    p_done_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i));

    p_result_holds_r11: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(from_o) && $stable(found_o)));

    p_empty_result_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !found_o |-> (from_o == '0));

    p_untried_pick_r10: assert property (@(posedge clk) disable iff (rst)
        found_o |-> !cap_tried[from_o]);

    p_own_colour_r8: assert property (@(posedge clk) disable iff (rst)
        found_o |-> ((sel.kind != PC_NONE) && (sel.black == cap_stm)));
endmodule

bind atk_src_finder atk_src_finder_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .board_i (board_i),
    .stm_i   (stm_i),
    .tried_i (tried_i),
    .start_i (start_i),
    .from_o  (from_o),
    .found_o (found_o),
    .done_o  (done_o)
);

// File: tb/tb_atk_src_finder.sv
module tb_atk_src_finder;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] WP = 4'h1, WN = 4'h2, WB = 4'h3, WR = 4'h4, WQ = 4'h5, WK = 4'h6;
    localparam logic [3:0] BP = 4'h9, BN = 4'hA, BR = 4'hC;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] board_i = '0;
    logic         stm_i = 1'b0;
    logic [5:0]   target_i = '0;
    logic [63:0]  tried_i = '0;
    logic         start_i = 1'b0;
    logic [5:0]   from_o;
    logic         found_o;
    logic         done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [6:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    atk_src_finder dut (
        .clk(clk), .rst(rst), .board_i(board_i), .stm_i(stm_i),
        .target_i(target_i), .tried_i(tried_i), .start_i(start_i),
        .from_o(from_o), .found_o(found_o), .done_o(done_o)
    );

    function automatic int iabs(int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic int sgn(int x);
        return (x > 0) ? 1 : ((x < 0) ? -1 : 0);
    endfunction

    function automatic int val_of(int kind);
        case (kind)
            1: return 1;
            2: return 3;
            3: return 3;
            4: return 5;
            5: return 9;
            6: return 12;
            default: return 99;
        endcase
    endfunction

    function automatic bit can_hit(logic [255:0] b, bit stm, int t, int s);
        int kind, col, df, dr, sf, sr, cf, cr;
        bit line, diagl;
        kind = int'(b[4*s +: 3]);
        col  = int'(b[4*s+3]);
        if (kind == 0 || col != int'(stm) || s == t) return 1'b0;
        df = (s % 8) - (t % 8);
        dr = (s / 8) - (t / 8);
        case (kind)
            1: return (iabs(df) == 1) && ((col == 1) ? (dr == 1) : (dr == -1));
            2: return (iabs(df) * iabs(dr) == 2);
            6: return (iabs(df) <= 1) && (iabs(dr) <= 1);
            default: begin
                line  = (df == 0) || (dr == 0);
                diagl = (iabs(df) == iabs(dr));
                if (kind == 3 && !diagl) return 1'b0;
                if (kind == 4 && !line) return 1'b0;
                if (kind == 5 && !line && !diagl) return 1'b0;
                sf = sgn(df);
                sr = sgn(dr);
                cf = (t % 8) + sf;
                cr = (t / 8) + sr;
                while ((cr * 8 + cf) != s) begin
                    if (b[4*(cr*8+cf) +: 3] != 3'd0) return 1'b0;
                    cf += sf;
                    cr += sr;
                end
                return 1'b1;
            end
        endcase
    endfunction

    function automatic logic [6:0] expect_of(logic [255:0] b, bit stm, int t, logic [63:0] tr);
        int bestv = 99;
        int bests = -1;
        for (int s = 0; s < 64; s++) begin
            if (!tr[s] && can_hit(b, stm, t, s) && val_of(int'(b[4*s +: 3])) < bestv) begin
                bestv = val_of(int'(b[4*s +: 3]));
                bests = s;
            end
        end
        if (bests < 0) return 7'd0;
        return {1'b1, 6'(bests)};
    endfunction

    function automatic logic [255:0] put(logic [255:0] b, int sq, logic [3:0] code);
        logic [255:0] r = b;
        r[4*sq +: 4] = code;
        return r;
    endfunction

    task automatic fail_line(string tag, string what, int got, int expv);
        n_bad++;
        $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
    endtask

    // driver: expectation first, then strobe
    task automatic request(logic [255:0] b, bit stm, int t, logic [63:0] tr, string tag);
        exp_q.push_back(expect_of(b, stm, t, tr));
        tag_q.push_back(tag);
        @(negedge clk);
        board_i  = b;
        stm_i    = stm;
        target_i = 6'(t);
        tried_i  = tr;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (done_o !== 1'b0) fail_line("R2", "done width", int'(done_o), 0);
    endtask

    // monitor: pop and compare on each done pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                fail_line("R2", "unexpected done", 1, 0);
            end else begin
                logic [6:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                if ({found_o, from_o} !== e)
                    $display("FAIL %s: got found=%0d from=%0d expected found=%0d from=%0d",
                             tg, found_o, from_o, e[6], e[5:0]);
                if ({found_o, from_o} !== e) n_bad++;
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [255:0] b;
        logic [6:0]   held;
        repeat (3) @(negedge clk);
        n_cmp++;
        if ({found_o, done_o, from_o} !== 8'd0) fail_line("R1", "reset outputs", int'({found_o, done_o, from_o}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R3: open file, then blocked file
        b = put('0, 27, BP);
        b = put(b, 59, WR);
        request(b, 0, 27, '0, "R3 rook open file");
        request(put(b, 43, BN), 0, 27, '0, "R3 rook blocked");
        request(put(put('0, 27, BP), 29, WQ), 0, 27, '0, "R3 queen on rank");

        // R4: diagonals, bishop from corner index 0
        request(put(put('0, 27, BP), 0, WB), 0, 27, '0, "R4 bishop a1");
        request(put(put(put('0, 27, BP), 0, WB), 9, WP), 0, 27, '0, "R4 bishop blocked");
        request(put(put('0, 27, BP), 63, WQ), 0, 27, '0, "R4 queen long diagonal");
        request(put(put('0, 27, BP), 59, WB), 0, 27, '0, "R4 bishop on file rejected");

        // R5: knight, including edge wrap
        request(put(put('0, 27, BP), 10, WN), 0, 27, '0, "R5 knight c2");
        request(put(put('0, 24, BP), 30, WN), 0, 24, '0, "R5 knight wrap rejected");
        request(put(put('0, 24, BP), 34, WN), 0, 24, '0, "R5 knight c5");

        // R6: king
        request(put(put('0, 27, BP), 36, WK), 0, 27, '0, "R6 king e5");
        request(put(put('0, 27, BP), 43, WK), 0, 27, '0, "R6 king two away rejected");

        // R7: pawn directions by colour
        request(put(put('0, 27, BP), 18, WP), 0, 27, '0, "R7 white pawn c3");
        request(put(put('0, 27, BP), 34, WP), 0, 27, '0, "R7 white pawn wrong side");
        request(put(put('0, 27, WP), 36, BP), 1, 27, '0, "R7 black pawn e5");
        request(put(put('0, 27, WP), 20, BP), 1, 27, '0, "R7 black pawn wrong side");
        request(put(put('0, 24, BP), 15, WP), 0, 24, '0, "R7 pawn wrap rejected");

        // rook edge wrap across ranks
        request(put(put('0, 24, BP), 23, WR), 0, 24, '0, "R3 rook wrap rejected");

        // R8: only opposing pieces present
        request(put(put(put('0, 27, WP), 59, BR), 10, BN), 0, 27, '0, "R8 enemy ignored");

        // R9: priority and ties
        b = put('0, 27, BP);
        b = put(b, 59, WQ);
        b = put(b, 18, WP);
        b = put(b, 10, WN);
        request(b, 0, 27, '0, "R9 pawn beats knight and queen");
        request(put(put(put('0, 27, BP), 12, WN), 10, WN), 0, 27, '0, "R9 knight tie low index");
        request(put(put(put('0, 27, BP), 0, WB), 10, WN), 0, 27, '0, "R9 bishop knight tie");
        request(put(put(put('0, 27, BP), 36, WK), 59, WQ), 0, 27, '0, "R9 queen beats king");

        // R10: tried mask
        request(b, 0, 27, 64'(1) << 18, "R10 skip tried pawn");
        request(b, 0, 27, (64'(1) << 18) | (64'(1) << 10), "R10 skip pawn and knight");
        request(b, 0, 27, (64'(1) << 18) | (64'(1) << 10) | (64'(1) << 59), "R10 all tried");

        // R11: outputs hold while inputs move without a strobe
        request(b, 0, 27, 64'(1) << 18, "R11 setup");
        held = {found_o, from_o};
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            board_i  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            target_i = 6'($urandom);
            tried_i  = '0;
            stm_i    = ~stm_i;
            @(negedge clk);
            n_cmp++;
            if ({found_o, from_o} !== held) fail_line("R11", "held result", int'({found_o, from_o}), int'(held));
        end

        // mixed positions for R3..R9
        for (int n = 0; n < 300; n++) begin
            logic [255:0] rb;
            logic [63:0]  rt;
            rb = '0;
            for (int s = 0; s < 64; s++) begin
                int kind;
                if (($urandom % 4) == 0) begin
                    kind = 1 + int'($urandom % 6);
                    rb[4*s +: 4] = {1'($urandom), 3'(kind)};
                end
            end
            rt = ((n % 3) == 0) ? {$urandom, $urandom} & {$urandom, $urandom} : '0;
            request(rb, 1'($urandom), int'($urandom % 64), rt, "R9 mixed position");
        end

        repeat (3) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) fail_line("R2", "pending results", exp_q.size(), 0);
        finish_run();
    end
endmodule